// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers data words from an asynchronous serial line whose frame format is set by static configuration inputs. The line is resynchronised into the clock domain. An idle-to-low transition marks a possible start bit. The receiver confirms that bit at its centre, then samples each data bit at its centre. When enabled, it samples a parity bit and checks it against the selected odd or even rule. It then checks the stop level early in the stop period.

Bit timing comes from one divisor input, `cfg_half_i`, which gives the number of clock cycles in half a bit period; a full bit lasts twice that. Each completed frame produces a one-cycle strobe that carries the word. Parity and framing errors appear as pulses in the same cycle as the strobe, so either can feed an interrupt line directly. The configuration inputs may change only while the line is idle.

Top module: `uart_frame_rx`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `perr_o` and `ferr_o` are 0 and `data_o` is 0.
- R2: A frame opens with one low bit period, followed by data bits sent least significant first. `cfg_len_i` selects the data width: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. At the end of the frame `valid_o` pulses high for exactly one cycle, and `data_o` then holds the word zero-extended to 8 bits.
- R3: If the line is high when sampled at the centre of the start bit, the receiver treats the low level as a glitch. It produces no strobe and waits for the next falling edge.
- R4: With `cfg_par_en_i` = 1, the bit after the last data bit is the parity bit. With `cfg_odd_i` = 1 (odd), the expected parity bit is 0 when the data holds an odd number of ones, and 1 otherwise. With `cfg_odd_i` = 0 (even), the expected parity bit is 1 when the count of ones is odd, and 0 otherwise. A mismatch makes `perr_o` pulse together with `valid_o`.
- R5: With `cfg_par_en_i` = 0, no parity bit is expected and `perr_o` stays 0.
- R6: The stop level is sampled at the middle of the first half-bit of the stop period. If it is low there, `ferr_o` pulses together with `valid_o`. The received word is still delivered.
- R7: The stop period lasts (`cfg_stop_i`+1) half-bits, that is 0.5, 1, 1.5 or 2 bit times. After that period the receiver is idle again, so a start bit that begins right at the end of the stop period is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| cfg_len_i | input | 2 | Data width code, 0..3 gives 5..8 bits |
| cfg_par_en_i | input | 1 | Parity bit present and checked |
| cfg_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop_i | input | 2 | Stop length in half-bits minus one |
| cfg_half_i | input | CNT_W | Clock cycles per half bit, at least 2 |
| valid_o | output | 1 | One-cycle strobe for a received word |
| data_o | output | 8 | Received word, zero-extended |
| perr_o | output | 1 | Parity error pulse, aligned with valid_o |
| ferr_o | output | 1 | Framing error pulse, aligned with valid_o |

## Verification
The bench keeps the default counter width and drives `cfg_half_i` = 4, which gives an 8-cycle bit. With a half-bit of 4 cycles, the stop-centre sample and the return to idle fall only a cycle or two apart. That spacing tests the stop counting in the half-bit stop mode, with frames sent back to back. The short bit also lets every combination of width, parity mode and stop length be exercised within a few thousand cycles, including a start glitch shorter than half a bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam int unsigned WORD_W = 8;

  // index of the last data bit for a width code (0..3 -> 4..7)
  function automatic logic [2:0] last_index(input logic [1:0] code);
    return {1'b0, code} + 3'd4;
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], rx_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rx_s_o = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] word_i,
  input  logic         en_i,
  input  logic         odd_i,
  input  logic         pbit_i,
  output logic         err_o
);
  logic expect_bit;

  // word is zero-extended, so reducing over all bits is exact
  assign expect_bit = odd_i ? ~^word_i : ^word_i;
  assign err_o      = en_i & (pbit_i != expect_bit);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_s_i,
  input  logic             fall_i,
  input  logic [1:0]       cfg_len_i,
  input  logic             cfg_par_en_i,
  input  logic [1:0]       cfg_stop_i,
  input  logic [CNT_W-1:0] cfg_half_i,
  output logic             stop_smp_o,
  output logic [W-1:0]     word_o,
  output logic             pbit_o
);
  localparam int unsigned LW = CNT_W + 3;
  localparam int unsigned IW = $clog2(W);

  rx_state_e       state_q;
  logic [LW-1:0]   cnt_q;
  logic [IW-1:0]   idx_q;
  logic [W-1:0]    word_q;
  logic            pbit_q;

  logic [LW-1:0] half_l, start_lim, bit_lim, smp_lim, end_lim;
  logic [IW-1:0] last_idx;

  always_comb begin
    half_l    = LW'(cfg_half_i);
    start_lim = half_l - LW'(1);
    bit_lim   = (half_l << 1) - LW'(1);
    smp_lim   = half_l + (half_l >> 1) - LW'(1);
    // stop ends (halves) half-bits after the end of the last bit
    end_lim   = half_l * (LW'(cfg_stop_i) + LW'(2)) - LW'(2);
    last_idx  = IW'(last_index(cfg_len_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      word_q  <= '0;
      pbit_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (fall_i) state_q <= ST_START;
        end
        ST_START: begin
          if (cnt_q == start_lim) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            word_q  <= '0;
            state_q <= rx_s_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_q <= cnt_q + LW'(1);
          end
        end
        ST_DATA: begin
          if (cnt_q == bit_lim) begin
            cnt_q         <= '0;
            word_q[idx_q] <= rx_s_i;
            if (idx_q == last_idx) state_q <= cfg_par_en_i ? ST_PAR : ST_STOP;
            else                   idx_q   <= idx_q + IW'(1);
          end else begin
            cnt_q <= cnt_q + LW'(1);
          end
        end
        ST_PAR: begin
          if (cnt_q == bit_lim) begin
            cnt_q   <= '0;
            pbit_q  <= rx_s_i;
            state_q <= ST_STOP;
          end else begin
            cnt_q <= cnt_q + LW'(1);
          end
        end
        ST_STOP: begin
          if (cnt_q == end_lim) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + LW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stop_smp_o = (state_q == ST_STOP) && (cnt_q == smp_lim);
  assign word_o     = word_q;
  assign pbit_o     = pbit_q;

  AST_GLITCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && cnt_q == start_lim && rx_s_i) |=> state_q == ST_IDLE); // R3
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && cnt_q == end_lim) |=> state_q == ST_IDLE); // R7
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA |-> idx_q <= last_idx); // R2
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [1:0]       cfg_len_i,
  input  logic             cfg_par_en_i,
  input  logic             cfg_odd_i,
  input  logic [1:0]       cfg_stop_i,
  input  logic [CNT_W-1:0] cfg_half_i,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             perr_o,
  output logic             ferr_o
);
  localparam int unsigned W = uart_rx_pkg::WORD_W;

  logic         rx_s, fall, stop_smp, pbit, par_err;
  logic [W-1:0] word;

  uart_rx_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (fall)
  );

  uart_rx_core #(.CNT_W(CNT_W), .W(W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_s_i       (rx_s),
    .fall_i       (fall),
    .cfg_len_i    (cfg_len_i),
    .cfg_par_en_i (cfg_par_en_i),
    .cfg_stop_i   (cfg_stop_i),
    .cfg_half_i   (cfg_half_i),
    .stop_smp_o   (stop_smp),
    .word_o       (word),
    .pbit_o       (pbit)
  );

  uart_rx_parity #(.W(W)) u_par (
    .word_i (word),
    .en_i   (cfg_par_en_i),
    .odd_i  (cfg_odd_i),
    .pbit_i (pbit),
    .err_o  (par_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= stop_smp;
      perr_o  <= stop_smp & par_err;
      ferr_o  <= stop_smp & ~rx_s;
      if (stop_smp) data_o <= word;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2
  AST_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg_len_i == 2'd0) |-> data_o[7:5] == 3'd0); // R2
  AST_PERR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> valid_o); // R4
  AST_NO_PERR_UNPAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_par_en_i |-> !perr_o); // R5
  AST_FERR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_o |-> valid_o); // R6
endmodule

// File: tb/sim_uart_frame_rx.sv
module sim_uart_frame_rx;
  localparam int HALF  = 4;
  localparam int CNT_W = 12;

  typedef struct packed {
    logic [1:0] len;
    logic       par;
    logic       odd;
    logic [1:0] stop;
    logic       flip;
    logic       slow;
    logic [7:0] data;
  } vec_t;

  // len, par_en, odd, stop, flip parity, low stop, data
  localparam vec_t VEC [8] = '{
    '{2'd3, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'hA5},
    '{2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 8'hFF},
    '{2'd1, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 8'h3C},
    '{2'd2, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 8'h55},
    '{2'd3, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 8'h80},
    '{2'd3, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 8'h81},
    '{2'd3, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 8'h0F},
    '{2'd0, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 8'hE6}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx = 1'b1;
  logic [1:0]       cfg_len = 2'd3;
  logic             cfg_par = 1'b0;
  logic             cfg_odd = 1'b0;
  logic [1:0]       cfg_stop = 2'd1;
  logic [CNT_W-1:0] cfg_half = CNT_W'(HALF);
  logic             valid, perr, ferr;
  logic [7:0]       data;

  int total = 0;
  int bad   = 0;
  int n_val = 0;
  int cycles = 0;
  logic [7:0] cap_d [32];
  logic       cap_p [32];
  logic       cap_f [32];

  always #2.5 clk = ~clk;

  uart_frame_rx #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .cfg_len_i(cfg_len), .cfg_par_en_i(cfg_par), .cfg_odd_i(cfg_odd),
    .cfg_stop_i(cfg_stop), .cfg_half_i(cfg_half),
    .valid_o(valid), .data_o(data), .perr_o(perr), .ferr_o(ferr)
  );

  always @(negedge clk) begin
    if (rst_n && valid && n_val < 32) begin
      cap_d[n_val] = data;
      cap_p[n_val] = perr;
      cap_f[n_val] = ferr;
    end
    if (rst_n && valid) n_val++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog R7: actual=%0d expected<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int n);
    rx = lvl;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mask_of(input logic [1:0] len);
    return 8'((9'd1 << (5 + len)) - 9'd1);
  endfunction

  task automatic send(input vec_t v, input bit gap);
    logic [7:0] d;
    logic       p;
    d = v.data & mask_of(v.len);
    p = (^d) ^ v.odd ^ v.flip;
    cfg_len = v.len; cfg_par = v.par; cfg_odd = v.odd; cfg_stop = v.stop;
    drive(1'b0, 2 * HALF);
    for (int i = 0; i < 5 + int'(v.len); i++) drive(d[i], 2 * HALF);
    if (v.par) drive(p, 2 * HALF);
    drive(~v.slow, HALF * (int'(v.stop) + 1));
    if (gap) drive(1'b1, 6 * HALF);
  endtask

  initial begin
    int base;
    vec_t b2b;
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R1 valid in reset", valid, 0);
    chk(perr == 1'b0 && ferr == 1'b0, "R1 errors in reset", {perr, ferr}, 0);
    chk(data == 8'h00, "R1 data in reset", data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R2 width/order, R4 parity, R5 no parity, R6 framing, R7 stop length
    for (int k = 0; k < 8; k++) begin
      base = n_val;
      send(VEC[k], 1'b1);
      chk(n_val == base + 1, $sformatf("R2 strobe count v%0d", k), n_val - base, 1);
      chk(cap_d[base] == (VEC[k].data & mask_of(VEC[k].len)),
          $sformatf("R2 data v%0d", k), cap_d[base], VEC[k].data & mask_of(VEC[k].len));
      chk(cap_p[base] == (VEC[k].par & VEC[k].flip),
          $sformatf("R4 R5 perr v%0d", k), cap_p[base], VEC[k].par & VEC[k].flip);
      chk(cap_f[base] == VEC[k].slow,
          $sformatf("R6 ferr v%0d", k), cap_f[base], VEC[k].slow);
    end

    // R3: short low pulse at start is rejected
    base = n_val;
    drive(1'b0, 2);
    drive(1'b1, 8 * HALF);
    chk(n_val == base, "R3 glitch strobe", n_val - base, 0);
    send('{2'd3, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'h3A}, 1'b1);
    chk(n_val == base + 1 && cap_d[base] == 8'h3A, "R3 frame after glitch", cap_d[base], 8'h3A);

    // R7: back-to-back frames with half-bit stop
    base = n_val;
    b2b = '{2'd3, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'hC3};
    send(b2b, 1'b0);
    b2b.data = 8'h5A;
    send(b2b, 1'b1);
    chk(n_val == base + 2, "R7 back-to-back count", n_val - base, 2);
    chk(cap_d[base] == 8'hC3, "R7 first word", cap_d[base], 8'hC3);
    chk(cap_d[base + 1] == 8'h5A, "R7 second word", cap_d[base + 1], 8'h5A);
    chk(cap_p[base] == 1'b0 && cap_p[base + 1] == 1'b0, "R7 R4 no perr", {cap_p[base], cap_p[base + 1]}, 0);

    // R1: reset mid-frame clears outputs and receiver recovers
    rx = 1'b0;
    repeat (3 * HALF) @(negedge clk);
    rst_n = 1'b0;
    rx = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0 && data == 8'h00, "R1 mid-frame reset", data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    base = n_val;
    send('{2'd2, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 8'h7E}, 1'b1);
    chk(n_val == base + 1 && cap_d[base] == 8'h7E && cap_p[base] == 1'b0,
        "R1 R4 frame after reset", cap_d[base], 8'h7E);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule